// File: doc/BRIEF.md
# Aligned Instruction Prefetch Buffer

This block sits between an instruction fetch unit and a 32-bit external bus. The fetch unit asks for one 16-bit instruction word at a time. The block never reads a single word from the bus. Each miss becomes a read of the whole long word that holds the requested word, at a long-word-aligned address. The returned 32 bits always go into a holding register, cacheable or not. Either half of that long word can then be served again with no bus cycle.

For an access marked cacheable, the full long word is also offered to the instruction cache as one fill entry. A flush input, driven on a branch or a context change, drops the holding register. A failed bus read returns an error flag with the word response and leaves the holding register empty.

Word requests and word responses use valid/ready handshakes. The block takes one request at a time. `req_ready` is high only while no request is in progress. A response holds `rsp_valid`, `rsp_word` and `rsp_err` unchanged until `rsp_ready` is sampled high. The bus request holds `bus_addr` stable until `bus_req_ready` is sampled high. The fill port is a plain one-cycle strobe with no back-pressure.

Top module: `instr_prefetch_buf`

## Requirements
- R1: A bus fetch presents `bus_addr` as the byte address of the requested word with bits 1:0 forced to 00. `bus_req_valid` and `bus_addr` stay stable until `bus_req_ready` is sampled high.
- R2: The word with word-address bit 0 equal to 0 is bits 31:16 of the long word. The word with bit 0 equal to 1 is bits 15:0.
- R3: After a fetch completes without error, a request whose word-address bits above bit 0 match the fetched line is a hit. This holds for cacheable and non-cacheable fetches alike. A hit issues no bus request, and its response is valid in the cycle after acceptance.
- R4: A request that misses (holding register empty, or a different line) raises `bus_req_valid` in the cycle after acceptance.
- R5: When a cacheable fetch completes without error, `fill_valid` pulses for exactly one cycle, in the same cycle the response first becomes valid. It carries the full long word on `fill_data` and the aligned address on `fill_addr`. A non-cacheable fetch gives no fill.
- R6: A flush empties the holding register, so the next request to the same line misses. A flush while a fetch is outstanding keeps that fetch's data out of the holding register, but the response is still returned.
- R7: A fetch that ends with `bus_err` returns `rsp_err`=1 and `rsp_word`=0, gives no fill, and leaves the holding register empty.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and unchanged, and `req_ready` stays low.
- R9: After reset, `req_ready` is 1, `rsp_valid`, `bus_req_valid` and `fill_valid` are 0, and the holding register is empty.
- R10: A flush in the same cycle a request is accepted makes that request a miss, even if its line was held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the holding register |
| req_valid | input | 1 | Word request valid |
| req_ready | output | 1 | Word request accepted |
| req_addr | input | 31 | Word address (byte address bits 31:1) |
| req_cacheable | input | 1 | Request may fill the instruction cache |
| rsp_valid | output | 1 | Word response valid |
| rsp_ready | input | 1 | Word response taken |
| rsp_word | output | 16 | Instruction word (0 on error) |
| rsp_err | output | 1 | Fetch ended in bus error |
| bus_req_valid | output | 1 | Long-word read request |
| bus_req_ready | input | 1 | Bus accepted the read |
| bus_addr | output | 32 | Aligned byte address of the read |
| bus_done | input | 1 | Read data returned this cycle |
| bus_err | input | 1 | Read ended in error (with `bus_done`) |
| bus_rdata | input | 32 | Returned long word |
| fill_valid | output | 1 | Cache fill strobe |
| fill_addr | output | 32 | Aligned byte address of the fill |
| fill_data | output | 32 | Long word for the cache entry |

## Verification
A hit response is due one cycle after the accepting edge. A miss raises `bus_req_valid` one cycle after the accepting edge. The response and any fill strobe are due one cycle after the edge that samples `bus_done`, and the fill strobe is gone one cycle after that. The bench drives inputs on falling edges and reads outputs on the next falling edge after the edge that should change them. One extra cycle is held at each handshake point to show that the bus request and the response stay stable under back-pressure. A table of requests walks hits, misses, both word halves, flush with a request, and bus errors. Directed cases follow for reset, a lone flush and a flush during an outstanding fetch.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } pfb_state_e;
endpackage

// File: rtl/pfb_word_sel.sv
module pfb_word_sel #(
  parameter int LINE_W = 32,
  parameter int WORD_W = 16,
  localparam int WORDS = LINE_W / WORD_W,
  localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] words [WORDS];

  // big-endian: lowest word address sits in the most significant bits
  for (genvar g = 0; g < WORDS; g++) begin : g_split
    assign words[g] = line_i[LINE_W-1-g*WORD_W -: WORD_W];
  end

  assign word_o = words[sel_i];
endmodule

// File: rtl/pfb_hold_reg.sv
module pfb_hold_reg #(
  parameter int TAG_W  = 30,
  parameter int LINE_W = 32,
  parameter int WORD_W = 16,
  localparam int WORDS = LINE_W / WORD_W,
  localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              inval_i,
  input  logic [TAG_W-1:0]  load_tag_i,
  input  logic [LINE_W-1:0] load_data_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  input  logic [SEL_W-1:0]  look_sel_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] hit_word_o
);
  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      data_q  <= '0;
    end else begin
      if (inval_i) begin
        valid_q <= 1'b0;
      end else if (load_i) begin
        valid_q <= 1'b1;
      end
      if (load_i && !inval_i) begin
        tag_q  <= load_tag_i;
        data_q <= load_data_i;
      end
    end
  end

  assign hit_o = valid_q && (tag_q == look_tag_i);

  pfb_word_sel #(.LINE_W(LINE_W), .WORD_W(WORD_W)) i_hold_sel (
    .line_i(data_q),
    .sel_i (look_sel_i),
    .word_o(hit_word_o)
  );

  AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inval_i |=> !hit_o); // R6
  AST_LOAD_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !inval_i) |=> (valid_q && tag_q == $past(load_tag_i))); // R3
endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
  import pfb_pkg::*;
#(
  parameter int WADDR_W = 31,
  parameter int LINE_W  = 32,
  parameter int WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [WADDR_W-1:0] req_addr_i,
  input  logic               req_cacheable_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [WORD_W-1:0]  rsp_word_o,
  output logic               rsp_err_o,
  output logic               bus_req_valid_o,
  input  logic               bus_req_ready_i,
  input  logic               bus_done_i,
  input  logic               bus_err_i,
  input  logic [LINE_W-1:0]  bus_rdata_i,
  input  logic [WORD_W-1:0]  bus_word_i,
  input  logic               hit_i,
  input  logic [WORD_W-1:0]  hit_word_i,
  output logic [WADDR_W-1:0] addr_o,
  output logic               load_o,
  output logic               inval_o,
  output logic               fill_valid_o,
  output logic [LINE_W-1:0]  fill_data_o
);
  pfb_state_e        state_q;
  logic [WADDR_W-1:0] addr_q;
  logic               cache_q;
  logic               stale_q;
  logic [WORD_W-1:0]  rsp_word_q;
  logic               rsp_err_q;
  logic               fill_v_q;
  logic [LINE_W-1:0]  fill_d_q;
  logic               done_now;

  assign done_now = (state_q == ST_WAIT) && bus_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      cache_q    <= 1'b0;
      stale_q    <= 1'b0;
      rsp_word_q <= '0;
      rsp_err_q  <= 1'b0;
      fill_v_q   <= 1'b0;
      fill_d_q   <= '0;
    end else begin
      fill_v_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            addr_q  <= req_addr_i;
            cache_q <= req_cacheable_i;
            stale_q <= 1'b0;
            if (hit_i && !flush_i) begin
              rsp_word_q <= hit_word_i;
              rsp_err_q  <= 1'b0;
              state_q    <= ST_RESP;
            end else begin
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (flush_i) stale_q <= 1'b1;
          if (bus_req_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (flush_i) stale_q <= 1'b1;
          if (bus_done_i) begin
            rsp_word_q <= bus_err_i ? '0 : bus_word_i;
            rsp_err_q  <= bus_err_i;
            fill_v_q   <= cache_q && !bus_err_i;
            fill_d_q   <= bus_rdata_i;
            state_q    <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign bus_req_valid_o = (state_q == ST_ISSUE);
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_word_o      = rsp_word_q;
  assign rsp_err_o       = rsp_err_q;
  assign addr_o          = addr_q;
  assign fill_valid_o    = fill_v_q;
  assign fill_data_o     = fill_d_q;
  assign load_o  = done_now && !bus_err_i && !stale_q && !flush_i;
  assign inval_o = flush_i || (done_now && bus_err_i);

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid_o && !bus_req_ready_i) |=> (bus_req_valid_o && $stable(addr_o))); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_word_o) && $stable(rsp_err_o))); // R8
  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o |=> !fill_valid_o); // R5
  AST_FILL_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o |-> (rsp_valid_o && !rsp_err_o)); // R7
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && hit_i && !flush_i) |=> (rsp_valid_o && !bus_req_valid_o)); // R3
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && flush_i) |=> bus_req_valid_o); // R10
  AST_NO_NEW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !req_ready_o); // R8
endmodule

// File: rtl/instr_prefetch_buf.sv
module instr_prefetch_buf #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 32,
  parameter int WORD_W = 16,
  localparam int OFF_LO  = $clog2(WORD_W / 8),
  localparam int WORDS   = LINE_W / WORD_W,
  localparam int SEL_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int WADDR_W = ADDR_W - OFF_LO,
  localparam int TAG_W   = WADDR_W - SEL_W,
  localparam int LINE_LO = OFF_LO + SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WADDR_W-1:0] req_addr,
  input  logic               req_cacheable,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [WORD_W-1:0]  rsp_word,
  output logic               rsp_err,
  output logic               bus_req_valid,
  input  logic               bus_req_ready,
  output logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_done,
  input  logic               bus_err,
  input  logic [LINE_W-1:0]  bus_rdata,
  output logic               fill_valid,
  output logic [ADDR_W-1:0]  fill_addr,
  output logic [LINE_W-1:0]  fill_data
);
  logic [WADDR_W-1:0] addr_q;
  logic               hit;
  logic [WORD_W-1:0]  hit_word;
  logic [WORD_W-1:0]  bus_word;
  logic               load;
  logic               inval;
  logic [ADDR_W-1:0]  line_addr;

  assign line_addr = {addr_q[WADDR_W-1:SEL_W], {LINE_LO{1'b0}}};
  assign bus_addr  = line_addr;
  assign fill_addr = line_addr;

  pfb_word_sel #(.LINE_W(LINE_W), .WORD_W(WORD_W)) i_bus_sel (
    .line_i(bus_rdata),
    .sel_i (addr_q[SEL_W-1:0]),
    .word_o(bus_word)
  );

  pfb_hold_reg #(.TAG_W(TAG_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) i_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .inval_i    (inval),
    .load_tag_i (addr_q[WADDR_W-1:SEL_W]),
    .load_data_i(bus_rdata),
    .look_tag_i (req_addr[WADDR_W-1:SEL_W]),
    .look_sel_i (req_addr[SEL_W-1:0]),
    .hit_o      (hit),
    .hit_word_o (hit_word)
  );

  pfb_ctrl #(.WADDR_W(WADDR_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) i_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush_i        (flush),
    .req_valid_i    (req_valid),
    .req_ready_o    (req_ready),
    .req_addr_i     (req_addr),
    .req_cacheable_i(req_cacheable),
    .rsp_valid_o    (rsp_valid),
    .rsp_ready_i    (rsp_ready),
    .rsp_word_o     (rsp_word),
    .rsp_err_o      (rsp_err),
    .bus_req_valid_o(bus_req_valid),
    .bus_req_ready_i(bus_req_ready),
    .bus_done_i     (bus_done),
    .bus_err_i      (bus_err),
    .bus_rdata_i    (bus_rdata),
    .bus_word_i     (bus_word),
    .hit_i          (hit),
    .hit_word_i     (hit_word),
    .addr_o         (addr_q),
    .load_o         (load),
    .inval_o        (inval),
    .fill_valid_o   (fill_valid),
    .fill_data_o    (fill_data)
  );

  AST_BUS_IDLE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !fill_valid); // R5
endmodule

// File: tb/test_instr_prefetch_buf.sv
module test_instr_prefetch_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [30:0] req_addr = '0;
  logic        req_cacheable = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_word;
  logic        rsp_err;
  logic        bus_req_valid;
  logic        bus_req_ready = 1'b0;
  logic [31:0] bus_addr;
  logic        bus_done = 1'b0;
  logic        bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        fill_valid;
  logic [31:0] fill_addr;
  logic [31:0] fill_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  instr_prefetch_buf i_instr_prefetch_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cacheable(req_cacheable),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_word(rsp_word), .rsp_err(rsp_err),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_addr(bus_addr),
    .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        cache;
    logic        flush_with;
    logic [31:0] data;
    logic        err;
    logic        miss;
    logic [15:0] word;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 1'b1, 1'b0, 32'hAAAA_BBBB, 1'b0, 1'b1, 16'hAAAA}, // R4 R2 first half
    '{32'h0000_1002, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 16'hBBBB}, // R3 R2 second half
    '{32'h0000_1000, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 16'hAAAA}, // R3
    '{32'h0000_2002, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 1'b1, 16'h5678}, // R1 R5 no fill
    '{32'h0000_2000, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0, 16'h1234}, // R3 uncached latch
    '{32'h0000_2002, 1'b1, 1'b1, 32'h1234_5678, 1'b0, 1'b1, 16'h5678}, // R10
    '{32'h0000_4002, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b1, 1'b1, 16'h0000}, // R7
    '{32'h0000_4000, 1'b1, 1'b0, 32'hCAFE_F00D, 1'b0, 1'b1, 16'hCAFE}, // R7 refetch
    '{32'h0000_4002, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0, 16'hF00D}  // R3
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input vec_t v, input logic mid_flush);
    logic [31:0] aligned;
    aligned = {v.addr[31:2], 2'b00};
    @(negedge clk);
    chk("R8", "req_ready before request", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_addr = v.addr[31:1]; req_cacheable = v.cache; flush = v.flush_with;
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0;
    chk(v.miss ? "R4" : "R3", "bus request after accept", {63'd0, bus_req_valid}, {63'd0, v.miss});
    if (v.miss) begin
      chk("R1", "aligned bus_addr", {32'd0, bus_addr}, {32'd0, aligned});
      @(negedge clk);
      chk("R1", "bus request held", {63'd0, bus_req_valid}, 64'd1);
      chk("R1", "bus_addr stable", {32'd0, bus_addr}, {32'd0, aligned});
      bus_req_ready = 1'b1;
      @(negedge clk);
      bus_req_ready = 1'b0; flush = mid_flush;
      @(negedge clk);
      flush = 1'b0;
      bus_done = 1'b1; bus_rdata = v.data; bus_err = v.err;
      @(negedge clk);
      bus_done = 1'b0; bus_err = 1'b0; bus_rdata = '0;
      chk("R5", "fill_valid", {63'd0, fill_valid}, {63'd0, v.cache && !v.err});
      if (v.cache && !v.err) begin
        chk("R5", "fill_data", {32'd0, fill_data}, {32'd0, v.data});
        chk("R5", "fill_addr", {32'd0, fill_addr}, {32'd0, aligned});
      end
    end
    chk("R3", "rsp_valid", {63'd0, rsp_valid}, 64'd1);
    chk("R2", "rsp_word", {48'd0, rsp_word}, {48'd0, v.word});
    chk("R7", "rsp_err", {63'd0, rsp_err}, {63'd0, v.err});
    @(negedge clk);
    chk("R5", "fill pulse ended", {63'd0, fill_valid}, 64'd0);
    chk("R8", "rsp held", {63'd0, rsp_valid}, 64'd1);
    chk("R8", "rsp_word held", {48'd0, rsp_word}, {48'd0, v.word});
    chk("R8", "req_ready low while busy", {63'd0, req_ready}, 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8", "rsp released", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "req_ready in reset", {63'd0, req_ready}, 64'd1);
    chk("R9", "rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    chk("R9", "bus_req_valid in reset", {63'd0, bus_req_valid}, 64'd0);
    chk("R9", "fill_valid in reset", {63'd0, fill_valid}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      do_req(VECS[i], 1'b0);
    end

    // R6 lone flush drops held line 0x4000
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_req('{32'h0000_4002, 1'b0, 1'b0, 32'h1111_2222, 1'b0, 1'b1, 16'h2222}, 1'b0);
    do_req('{32'h0000_4000, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0, 16'h1111}, 1'b0);

    // R6 flush during outstanding fetch: response delivered, line not kept
    do_req('{32'h0000_5000, 1'b1, 1'b0, 32'h5555_6666, 1'b0, 1'b1, 16'h5555}, 1'b1);
    do_req('{32'h0000_5002, 1'b1, 1'b0, 32'h5555_6666, 1'b0, 1'b1, 16'h6666}, 1'b0);
    do_req('{32'h0000_5000, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 16'h5555}, 1'b0);

    // R9 reset mid-run empties the holding register
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_req('{32'h0000_5000, 1'b0, 1'b0, 32'h7777_8888, 1'b0, 1'b1, 16'h7777}, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule